// File: doc/BRIEF.md
# Sleep and Wake Controller

This block sequences a small processor core into and out of its low-power halt. The instruction decoder pulses a sleep request. If an enabled interrupt is already pending at that moment, the request has no effect. Otherwise the core is halted, the power-down status bit goes low and the timeout status bit goes high. While halted, the block watches two kinds of event. The first kind is a qualified interrupt. The second is a reset source whose enable is set; power-on reset needs no enable.

On a wake event the block issues a one-cycle watchdog clear. It then holds the core halted until three readiness inputs agree: program memory, the selected oscillator and the brown-out circuit. The brown-out input is not consulted when brown-out reset is disabled.

An interrupt wake lets the core run one instruction slot. If global interrupts were enabled in that slot, the block then asks for a jump to the service routine. A reset wake instead issues a reset request and restores the status bits. A reset source seen while the core runs does the same at once.

Top module: `slumberCtl`

## Requirements
- R1: After reset, coreHalt, wdtClear, resetReq, isrReq and wakeWasReset are 0, and pdBit and toBit are 1.
- R2: A sleepReq pulse with no qualified pending interrupt and no reset event raises coreHalt one cycle later, with pdBit = 0 and toBit = 1.
- R3: A sleepReq pulse while a qualified interrupt is pending leaves coreHalt at 0, leaves pdBit unchanged and produces no wdtClear pulse.
- R4: Interrupt bit i is qualified when intEn[i] and intFlag[i] are both 1. Bits at index PRIM_CNT (default 4) and above also need periphEn = 1. Bit CLKSW_IDX (default 2) is never qualified. Unqualified bits neither block sleep nor wake the core.
- R5: In the cycle after a wake event, wdtClear is 1 for exactly one cycle and coreHalt remains 1.
- R6: After a wake event, coreHalt stays 1 until memReady, oscReady and either borReady or a low borEn all hold.
- R7: On an interrupt wake, the first ready cycle drops coreHalt with no resetReq, whatever globalEn is. If globalEn is 1 in that resume cycle, isrReq pulses for one cycle in the following cycle; otherwise isrReq stays 0.
- R8: On a reset wake, the first ready cycle drops coreHalt and pulses resetReq for one cycle, with pdBit = 1, toBit = 1 and wakeWasReset = 1.
- R9: A reset wake caused by wdtExpire with wdtEn = 1 leaves toBit = 0 and pdBit = 1.
- R10: extRstPin, borTrip, lpborTrip and wdtExpire have no effect while their enables are 0.
- R11: A reset event while the core runs pulses resetReq in the next cycle and sets pdBit to 1 and toBit to 1 (toBit to 0 for a watchdog reset).
- R12: After an interrupt wake, wakeWasReset is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sleepReq | input | 1 | Sleep strobe from the decoder |
| intEn | input | INT_W | Interrupt enable bits |
| intFlag | input | INT_W | Interrupt flag bits |
| periphEn | input | 1 | Peripheral interrupt enable |
| globalEn | input | 1 | Global interrupt enable |
| extRstPin | input | 1 | External reset pin event |
| extRstEn | input | 1 | External reset enable |
| borTrip | input | 1 | Brown-out reset event |
| borEn | input | 1 | Brown-out reset enable |
| lpborTrip | input | 1 | Low-power brown-out reset event |
| lpborEn | input | 1 | Low-power brown-out enable |
| porTrip | input | 1 | Power-on reset event |
| wdtExpire | input | 1 | Watchdog timeout event |
| wdtEn | input | 1 | Watchdog enable |
| memReady | input | 1 | Program memory ready |
| oscReady | input | 1 | Selected oscillator ready |
| borReady | input | 1 | Brown-out circuit ready |
| coreHalt | output | 1 | Core halted |
| wdtClear | output | 1 | Watchdog and prescaler clear pulse |
| toBit | output | 1 | Timeout status, low after watchdog reset |
| pdBit | output | 1 | Power-down status, low after sleep entry |
| resetReq | output | 1 | Device reset request pulse |
| isrReq | output | 1 | Vector-to-service-routine pulse |
| wakeWasReset | output | 1 | Last wake or event was a reset |

## Verification
The hardest situation to reach is a wake that has to wait on the readiness gate. To get there, the bench must first bring the core into sleep, then withdraw one readiness input before the wake event, and finally keep the core halted while the inputs are released one at a time. The brown-out input is released last, and only by disabling brown-out reset. The bench drives this sequence directly. A vector table then covers interrupt qualification on sleep entry. Each sleep entry that succeeds in that table is closed with an interrupt wake, so every vector starts from the running state.

// File: rtl/pmPkg.sv
package pmPkg;
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_SLEEP  = 2'd1,
    ST_WAIT   = 2'd2,
    ST_RESUME = 2'd3
  } pmState_t;

  typedef struct packed {
    logic enterSleep;
    logic wakeStart;
    logic captureCause;
    logic fireReset;
    logic fireIsr;
  } pmStrobe_t;
endpackage

// File: rtl/pmDatapath.sv
module pmDatapath
  import pmPkg::*;
#(
  parameter int INT_W     = 8,
  parameter int PRIM_CNT  = 4,
  parameter int CLKSW_IDX = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [INT_W-1:0] intEn,
  input  logic [INT_W-1:0] intFlag,
  input  logic             periphEn,
  input  logic             extRstPin,
  input  logic             extRstEn,
  input  logic             borTrip,
  input  logic             borEn,
  input  logic             lpborTrip,
  input  logic             lpborEn,
  input  logic             porTrip,
  input  logic             wdtExpire,
  input  logic             wdtEn,
  input  logic             memReady,
  input  logic             oscReady,
  input  logic             borReady,
  input  pmStrobe_t        strobe,
  output logic             intPending,
  output logic             resetEvt,
  output logic             allReady,
  output logic             causeReset,
  output logic             toBit,
  output logic             pdBit,
  output logic             wdtClear,
  output logic             resetReq,
  output logic             isrReq
);
  logic [INT_W-1:0] qualified;
  logic             wdtEvt;
  logic             causeWdt;

  for (genvar i = 0; i < INT_W; i++) begin : g_qual
    if (i == CLKSW_IDX) begin : g_clksw
      assign qualified[i] = 1'b0;
    end else if (i < PRIM_CNT) begin : g_prim
      assign qualified[i] = intEn[i] & intFlag[i];
    end else begin : g_periph
      assign qualified[i] = intEn[i] & intFlag[i] & periphEn;
    end
  end

  assign intPending = |qualified;
  assign wdtEvt     = wdtExpire & wdtEn;
  assign resetEvt   = (extRstPin & extRstEn) | (borTrip & borEn) |
                      (lpborTrip & lpborEn) | porTrip | wdtEvt;
  assign allReady   = memReady & oscReady & (borReady | ~borEn);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      causeReset <= 1'b0;
      causeWdt   <= 1'b0;
      toBit      <= 1'b1;
      pdBit      <= 1'b1;
      wdtClear   <= 1'b0;
      resetReq   <= 1'b0;
      isrReq     <= 1'b0;
    end else begin
      wdtClear <= strobe.wakeStart;
      resetReq <= strobe.fireReset;
      isrReq   <= strobe.fireIsr;
      if (strobe.wakeStart) begin
        causeReset <= resetEvt;
        causeWdt   <= wdtEvt;
      end else if (strobe.captureCause) begin
        causeReset <= causeReset | resetEvt;
        causeWdt   <= causeWdt | wdtEvt;
      end
      if (strobe.enterSleep) begin
        pdBit <= 1'b0;
        toBit <= 1'b1;
      end
      if (strobe.fireReset) begin
        pdBit      <= 1'b1;
        toBit      <= ~(wdtEvt | causeWdt);
        causeWdt   <= 1'b0;
        causeReset <= 1'b1;
      end
    end
  end

  p_sleep_pd_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.enterSleep |=> (!pdBit && toBit));
  p_wdtclr_once_r5: assert property (@(posedge clk) disable iff (!rstN)
    wdtClear |=> !wdtClear);
  p_isr_once_r7: assert property (@(posedge clk) disable iff (!rstN)
    isrReq |=> !isrReq);
  p_reset_status_r8: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> pdBit);
endmodule

// File: rtl/pmControl.sv
module pmControl
  import pmPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      sleepReq,
  input  logic      globalEn,
  input  logic      intPending,
  input  logic      resetEvt,
  input  logic      allReady,
  input  logic      causeReset,
  output pmStrobe_t strobe,
  output logic      coreHalt
);
  pmState_t state, stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_RUN: begin
        if (resetEvt) begin
          strobe.fireReset = 1'b1;
        end else if (sleepReq && !intPending) begin
          strobe.enterSleep = 1'b1;
          stateNext         = ST_SLEEP;
        end
      end
      ST_SLEEP: begin
        if (resetEvt || intPending) begin
          strobe.wakeStart = 1'b1;
          stateNext        = ST_WAIT;
        end
      end
      ST_WAIT: begin
        strobe.captureCause = 1'b1;
        if (allReady) begin
          if (causeReset || resetEvt) begin
            strobe.fireReset = 1'b1;
            stateNext        = ST_RUN;
          end else begin
            stateNext = ST_RESUME;
          end
        end
      end
      ST_RESUME: begin
        strobe.fireIsr = globalEn;
        stateNext      = ST_RUN;
      end
      default: stateNext = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_RUN;
    else       state <= stateNext;
  end

  assign coreHalt = (state == ST_SLEEP) || (state == ST_WAIT);

  p_enter_halt_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && sleepReq && !intPending && !resetEvt) |=> coreHalt);
  p_noop_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && sleepReq && intPending) |=> !coreHalt);
  p_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && !allReady) |=> coreHalt);
  p_resume_one_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RESUME) |=> (state == ST_RUN));
endmodule

// File: rtl/slumberCtl.sv
module slumberCtl
  import pmPkg::*;
#(
  parameter int INT_W     = 8,
  parameter int PRIM_CNT  = 4,
  parameter int CLKSW_IDX = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sleepReq,
  input  logic [INT_W-1:0] intEn,
  input  logic [INT_W-1:0] intFlag,
  input  logic             periphEn,
  input  logic             globalEn,
  input  logic             extRstPin,
  input  logic             extRstEn,
  input  logic             borTrip,
  input  logic             borEn,
  input  logic             lpborTrip,
  input  logic             lpborEn,
  input  logic             porTrip,
  input  logic             wdtExpire,
  input  logic             wdtEn,
  input  logic             memReady,
  input  logic             oscReady,
  input  logic             borReady,
  output logic             coreHalt,
  output logic             wdtClear,
  output logic             toBit,
  output logic             pdBit,
  output logic             resetReq,
  output logic             isrReq,
  output logic             wakeWasReset
);
  pmStrobe_t strobe;
  logic      intPending;
  logic      resetEvt;
  logic      allReady;
  logic      causeReset;

  pmControl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sleepReq   (sleepReq),
    .globalEn   (globalEn),
    .intPending (intPending),
    .resetEvt   (resetEvt),
    .allReady   (allReady),
    .causeReset (causeReset),
    .strobe     (strobe),
    .coreHalt   (coreHalt)
  );

  pmDatapath #(
    .INT_W     (INT_W),
    .PRIM_CNT  (PRIM_CNT),
    .CLKSW_IDX (CLKSW_IDX)
  ) u_data (
    .clk        (clk),
    .rstN       (rstN),
    .intEn      (intEn),
    .intFlag    (intFlag),
    .periphEn   (periphEn),
    .extRstPin  (extRstPin),
    .extRstEn   (extRstEn),
    .borTrip    (borTrip),
    .borEn      (borEn),
    .lpborTrip  (lpborTrip),
    .lpborEn    (lpborEn),
    .porTrip    (porTrip),
    .wdtExpire  (wdtExpire),
    .wdtEn      (wdtEn),
    .memReady   (memReady),
    .oscReady   (oscReady),
    .borReady   (borReady),
    .strobe     (strobe),
    .intPending (intPending),
    .resetEvt   (resetEvt),
    .allReady   (allReady),
    .causeReset (causeReset),
    .toBit      (toBit),
    .pdBit      (pdBit),
    .wdtClear   (wdtClear),
    .resetReq   (resetReq),
    .isrReq     (isrReq)
  );

  assign wakeWasReset = causeReset;
endmodule

// File: tb/slumberCtl_test.sv
module slumberCtl_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sleepReq = 1'b0;
  logic [7:0] intEn = '0;
  logic [7:0] intFlag = '0;
  logic       periphEn = 1'b0, globalEn = 1'b0;
  logic       extRstPin = 1'b0, extRstEn = 1'b0;
  logic       borTrip = 1'b0, borEn = 1'b0;
  logic       lpborTrip = 1'b0, lpborEn = 1'b0;
  logic       porTrip = 1'b0;
  logic       wdtExpire = 1'b0, wdtEn = 1'b0;
  logic       memReady = 1'b1, oscReady = 1'b1, borReady = 1'b1;
  logic       coreHalt, wdtClear, toBit, pdBit, resetReq, isrReq, wakeWasReset;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  slumberCtl uut (
    .clk(clk), .rstN(rstN), .sleepReq(sleepReq), .intEn(intEn), .intFlag(intFlag),
    .periphEn(periphEn), .globalEn(globalEn), .extRstPin(extRstPin), .extRstEn(extRstEn),
    .borTrip(borTrip), .borEn(borEn), .lpborTrip(lpborTrip), .lpborEn(lpborEn),
    .porTrip(porTrip), .wdtExpire(wdtExpire), .wdtEn(wdtEn), .memReady(memReady),
    .oscReady(oscReady), .borReady(borReady), .coreHalt(coreHalt), .wdtClear(wdtClear),
    .toBit(toBit), .pdBit(pdBit), .resetReq(resetReq), .isrReq(isrReq),
    .wakeWasReset(wakeWasReset)
  );

  // {intEn, intFlag, periphEn, expectSleep}
  localparam logic [17:0] VEC [0:7] = '{
    {8'h00, 8'hFF, 1'b1, 1'b1},
    {8'h01, 8'h01, 1'b0, 1'b0},
    {8'h04, 8'h04, 1'b1, 1'b1},
    {8'h10, 8'h10, 1'b0, 1'b1},
    {8'h10, 8'h10, 1'b1, 1'b0},
    {8'h0F, 8'hF0, 1'b1, 1'b1},
    {8'h80, 8'h80, 1'b1, 1'b0},
    {8'h08, 8'h08, 1'b0, 1'b0}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic enterSleep();
    sleepReq = 1'b1;
    tick();
    sleepReq = 1'b0;
  endtask

  task automatic wakeByInt();
    intEn = 8'h01; intFlag = 8'h01;
    tick();
    intEn = '0; intFlag = '0;
    tick();
    tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic prevPd;
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    // R1 reset state
    chk("R1 coreHalt", coreHalt, 0);
    chk("R1 pdBit", pdBit, 1);
    chk("R1 toBit", toBit, 1);
    chk("R1 pulses", {wdtClear, resetReq, isrReq, wakeWasReset}, 0);

    // R3 and R4: sleep entry against the qualification table
    for (int i = 0; i < 8; i++) begin
      intEn = VEC[i][17:10];
      intFlag = VEC[i][9:2];
      periphEn = VEC[i][1];
      prevPd = pdBit;
      enterSleep();
      chk($sformatf("R4 vec%0d halt", i), coreHalt, VEC[i][0]);
      chk($sformatf("R3 vec%0d pdBit", i), pdBit, VEC[i][0] ? 1'b0 : prevPd);
      chk($sformatf("R3 vec%0d wdtClear", i), wdtClear, 0);
      intEn = '0; intFlag = '0; periphEn = 1'b0;
      if (VEC[i][0]) wakeByInt();
    end

    // R2, R5, R6, R7, R12: gated interrupt wake with global enable
    enterSleep();
    chk("R2 halt", coreHalt, 1);
    chk("R2 status", {pdBit, toBit}, 2'b01);
    memReady = 1'b0;
    intEn = 8'h01; intFlag = 8'h01;
    tick();
    chk("R5 wdtClear high", wdtClear, 1);
    chk("R5 halt kept", coreHalt, 1);
    intEn = '0; intFlag = '0;
    tick();
    chk("R5 wdtClear low", wdtClear, 0);
    chk("R6 halt no mem", coreHalt, 1);
    memReady = 1'b1; borEn = 1'b1; borReady = 1'b0;
    tick();
    chk("R6 halt no bor", coreHalt, 1);
    borEn = 1'b0; globalEn = 1'b1;
    tick();
    chk("R6 bor ignored halt", coreHalt, 0);
    chk("R7 no resetReq", resetReq, 0);
    tick();
    chk("R7 isrReq pulse", isrReq, 1);
    globalEn = 1'b0; borReady = 1'b1;
    tick();
    chk("R7 isrReq one cycle", isrReq, 0);
    chk("R12 wakeWasReset", wakeWasReset, 0);

    // R7 without global enable
    enterSleep();
    intEn = 8'h01; intFlag = 8'h01;
    tick();
    intEn = '0; intFlag = '0;
    tick();
    chk("R7 resume without gie", coreHalt, 0);
    tick();
    chk("R7 no isrReq", isrReq, 0);

    // R4 in sleep, R10, R8
    enterSleep();
    intEn = 8'h14; intFlag = 8'h14; periphEn = 1'b0;
    tick();
    chk("R4 no wake", {coreHalt, wdtClear}, 2'b10);
    intEn = '0; intFlag = '0;
    extRstPin = 1'b1; borTrip = 1'b1; lpborTrip = 1'b1; wdtExpire = 1'b1;
    tick();
    chk("R10 disabled resets", {coreHalt, wdtClear}, 2'b10);
    borTrip = 1'b0; lpborTrip = 1'b0; wdtExpire = 1'b0;
    extRstEn = 1'b1;
    tick();
    chk("R8 wake wdtClear", wdtClear, 1);
    extRstPin = 1'b0; extRstEn = 1'b0;
    tick();
    chk("R8 resetReq", resetReq, 1);
    chk("R8 status", {coreHalt, pdBit, toBit, wakeWasReset}, 4'b0111);
    tick();
    chk("R8 resetReq one cycle", resetReq, 0);

    // R9 watchdog reset wake
    enterSleep();
    wdtEn = 1'b1; wdtExpire = 1'b1;
    tick();
    chk("R9 wdtClear", wdtClear, 1);
    wdtExpire = 1'b0; wdtEn = 1'b0;
    tick();
    chk("R9 resetReq", resetReq, 1);
    chk("R9 status", {pdBit, toBit}, 2'b10);

    // R11 reset while running
    tick();
    porTrip = 1'b1;
    tick();
    porTrip = 1'b0;
    chk("R11 resetReq", resetReq, 1);
    chk("R11 status", {coreHalt, pdBit, toBit}, 3'b011);
    tick();
    chk("R11 one cycle", resetReq, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule